// File: doc/BRIEF.md
# DRAM Cycle Decoder Model

This block is a synthesizable, device-side model of a one-bit-wide asynchronous DRAM for simulation or FPGA use. All inputs are active-low strobes (row strobe, column strobe, write enable) plus a multiplexed address and a data-in bit. A system clock samples them, and the block works out which kind of memory cycle the host is running from the order in which the strobes change. It does not decode explicit commands.

Several cycle kinds are recognised: plain read, early write, read-modify-write, page-mode accesses within one open row, row-only refresh, column-before-row refresh and hidden refresh. The model drives a data-out bit and a separate output-enable, so a board-level wrapper can build the three-state pin. It holds an internal refresh row counter that steps on every column-before-row refresh. The storage array is parameterized: 10 row and 10 column bits give the full one-megabit size, and the defaults are reduced to 4 and 4 for simulation.

Every strobe is assumed to be synchronous to `clk` and held for at least one clock. Every output is registered. A strobe change sampled at a rising edge shows its effect from that edge on.

Top module: `dram_cycle_model`

## Requirements
- R1: When the row strobe falls while the column strobe is high, the low ROW_W address bits are latched as the open row and `cycle_kind` becomes 1 (row open).
- R2: When the row strobe rises and no column strobe fall came after the row was opened, `cycle_kind` becomes 5 (row-only refresh). `refresh_pulse` is high for exactly one cycle, `refresh_row` equals the latched row, and `dout_oe` is 0.
- R3: When the column strobe falls with write enable low, `din` is stored at {open row, low COL_W address bits} and `cycle_kind` becomes 3 (early write). `dout_oe` stays 0 for as long as `cycle_kind` remains 3.
- R4: When the column strobe falls with write enable high, `dout` takes the addressed cell, `dout_oe` becomes 1 and `cycle_kind` becomes 2 (read).
- R5: When write enable falls during a read while the column strobe is still low, `din` is written to the same cell and `cycle_kind` becomes 4 (read-modify-write). `dout` keeps the value that was read and `dout_oe` stays 1.
- R6: A rising column strobe clears `dout_oe` at the edge where it is sampled.
- R7: While the row strobe stays low, each further column strobe fall accesses a new column in the same row. `page_access` is 0 for the first access after the row opens and 1 for each later one.
- R8: When the row strobe falls while the column strobe is already low, a column-before-row refresh starts. `cycle_kind` becomes 6, `refresh_pulse` is high for one cycle and `refresh_row` shows the internal counter. The address, write enable and `din` are ignored, so no cell changes.
- R9: The refresh counter resets to 0. It advances by one after each column-before-row refresh (R8 or R10) and wraps from 2^ROW_W-1 to 0.
- R10: When a read leaves the column strobe low and the row strobe rises and then falls again, `cycle_kind` becomes 7 (hidden refresh). A refresh is done as in R8, while `dout` and `dout_oe` keep the read data until the column strobe rises.
- R11: During and right after reset, `dout_oe` is 0, `cycle_kind` is 0 (idle) and `refresh_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | 1 | Write data bit |
| dout | output | 1 | Read data bit |
| dout_oe | output | 1 | Drive enable for the data-out pin |
| cycle_kind | output | 3 | Cycle classification (codes in R1 to R10, 0 idle) |
| page_access | output | 1 | Current access is a follow-on page access |
| refresh_pulse | output | 1 | One-cycle marker of a refresh |
| refresh_row | output | ROW_W | Row refreshed by the latest refresh |

## Verification
Every result is due at the rising edge that first samples the strobe change that causes it. The bench changes inputs on a falling edge and reads outputs on the next falling edge, which is exactly one clock later and half a period clear of either edge. The refresh marker is checked both in that cycle and in the cycle after, to confirm it lasts one clock. Hidden refresh and read-modify-write are checked over several samples, because their data must stay unchanged across later strobe edges rather than merely appear.

// File: rtl/dram_cyc_pkg.sv
// Shared types for the DRAM cycle decoder model.
// Assumes: nothing beyond IEEE 1800-2017.
package dram_cyc_pkg;

    // Externally visible cycle classification (codes fixed by the brief)
    typedef enum logic [2:0] {
        KIND_IDLE        = 3'd0,
        KIND_ROW_OPEN    = 3'd1,
        KIND_READ        = 3'd2,
        KIND_EARLY_WRITE = 3'd3,
        KIND_RMW         = 3'd4,
        KIND_RAS_ONLY    = 3'd5,
        KIND_CBR         = 3'd6,
        KIND_HIDDEN      = 3'd7
    } cycle_kind_e;

    // Internal phase of the current row-strobe period
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ROW,
        PH_READ,
        PH_WRITE,
        PH_RMW,
        PH_REFRESH
    } phase_e;

    // Bit positions of the strobes in the edge detector vector
    localparam int STROBE_RAS  = 0;
    localparam int STROBE_CAS  = 1;
    localparam int STROBE_WE   = 2;
    localparam int NUM_STROBES = 3;

endpackage

// File: rtl/dram_strobe_edges.sv
// Edge detector for a vector of active-low strobes.
// Does: keeps the previous sample of each strobe and flags falls and rises.
// Assumes: strobes are synchronous to clk; reset treats all strobes as high
// (inactive), so a strobe held low through reset shows a fall at release.
module dram_strobe_edges #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level_n,
    output logic [N-1:0] fall,
    output logic [N-1:0] rise
);

    for (genvar i = 0; i < N; i++) begin : g_strobe
        logic prev_q;

        // Remember last sampled level of this strobe
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b1;
            else        prev_q <= level_n[i];
        end

        assign fall[i] = prev_q & ~level_n[i];
        assign rise[i] = ~prev_q & level_n[i];
    end

endmodule

// File: rtl/dram_refresh_counter.sv
// Internal refresh row counter.
// Does: presents the next row to refresh and steps once per advance request,
// wrapping after the last row.
// Assumes: ROWS <= 2**ROW_W.
module dram_refresh_counter #(
    parameter int ROW_W = 4,
    parameter int ROWS  = 1 << ROW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [ROW_W-1:0] row
);

    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

    logic [ROW_W-1:0] cnt_q;

    // Step and wrap the refresh pointer
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (advance) begin
            if (cnt_q == LAST_ROW) cnt_q <= '0;
            else                   cnt_q <= cnt_q + 1'b1;
        end
    end

    assign row = cnt_q;

endmodule

// File: rtl/dram_bit_array.sv
// One-bit-wide storage array.
// Does: synchronous single-bit write, combinational single-bit read.
// Assumes: contents are not reset (a real array is not); readers write
// before they read.
module dram_bit_array #(
    parameter int ADDR_BITS = 8
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [ADDR_BITS-1:0] wr_addr,
    input  logic                 wr_bit,
    input  logic [ADDR_BITS-1:0] rd_addr,
    output logic                 rd_bit
);

    localparam int DEPTH = 1 << ADDR_BITS;

    logic cells [DEPTH];

    // Store one bit on request
    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_addr] <= wr_bit;
    end

    assign rd_bit = cells[rd_addr];

endmodule

// File: rtl/dram_cycle_model.sv
// DRAM cycle decoder model (top).
// Does: samples the row/column/write strobes, classifies each memory cycle
// from their edge order, performs reads, writes and refreshes on the array,
// and drives data-out with a separate enable.
// Assumes: strobes and address synchronous to clk, each level held for at
// least one clock; analog timing is not modelled.
module dram_cycle_model
    import dram_cyc_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 4,
    parameter int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic              dout,
    output logic              dout_oe,
    output logic [2:0]        cycle_kind,
    output logic              page_access,
    output logic              refresh_pulse,
    output logic [ROW_W-1:0]  refresh_row
);

    localparam int CELL_W = ROW_W + COL_W;
    localparam int ROWS   = 1 << ROW_W;

    // Strobe edges
    logic [NUM_STROBES-1:0] strobe_lvl, strobe_fall, strobe_rise;
    logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
    logic we_rise_unused;

    assign strobe_lvl[STROBE_RAS] = ras_n;
    assign strobe_lvl[STROBE_CAS] = cas_n;
    assign strobe_lvl[STROBE_WE]  = we_n;

    dram_strobe_edges #(.N(NUM_STROBES)) edges_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_n (strobe_lvl),
        .fall    (strobe_fall),
        .rise    (strobe_rise)
    );

    assign ras_fall       = strobe_fall[STROBE_RAS];
    assign ras_rise       = strobe_rise[STROBE_RAS];
    assign cas_fall       = strobe_fall[STROBE_CAS];
    assign cas_rise       = strobe_rise[STROBE_CAS];
    assign we_fall        = strobe_fall[STROBE_WE];
    assign we_rise_unused = strobe_rise[STROBE_WE];

    // Registered state
    phase_e           phase_q,  phase_d;
    cycle_kind_e      kind_q,   kind_d;
    logic [ROW_W-1:0] row_q,    row_d;
    logic [COL_W-1:0] col_q,    col_d;
    logic             seen_q,   seen_d;
    logic             dout_q,   dout_d;
    logic             oe_q,     oe_d;
    logic             page_q,   page_d;
    logic             pulse_q,  pulse_d;
    logic [ROW_W-1:0] rrow_q,   rrow_d;

    // Refresh counter and array hookup
    logic              cnt_adv;
    logic [ROW_W-1:0]  cnt_row;
    logic              wr_en;
    logic [CELL_W-1:0] wr_addr, rd_addr;
    logic [COL_W-1:0]  col_in;
    logic              rd_bit;

    assign col_in  = addr[COL_W-1:0];
    assign rd_addr = {row_q, col_in};

    dram_refresh_counter #(.ROW_W(ROW_W), .ROWS(ROWS)) refcnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (cnt_adv),
        .row     (cnt_row)
    );

    dram_bit_array #(.ADDR_BITS(CELL_W)) array_i (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_bit  (din),
        .rd_addr (rd_addr),
        .rd_bit  (rd_bit)
    );

    // Classify the sampled edge pattern and decide the next state
    always_comb begin
        phase_d = phase_q;
        kind_d  = kind_q;
        row_d   = row_q;
        col_d   = col_q;
        seen_d  = seen_q;
        dout_d  = dout_q;
        oe_d    = oe_q;
        page_d  = page_q;
        pulse_d = 1'b0;
        rrow_d  = rrow_q;
        cnt_adv = 1'b0;
        wr_en   = 1'b0;
        wr_addr = {row_q, col_q};

        if (cas_rise) oe_d = 1'b0;

        if (ras_fall) begin
            if (!cas_n) begin
                // Column strobe already low: refresh from the counter
                kind_d  = oe_q ? KIND_HIDDEN : KIND_CBR;
                phase_d = PH_REFRESH;
                pulse_d = 1'b1;
                rrow_d  = cnt_row;
                cnt_adv = 1'b1;
            end else begin
                kind_d  = KIND_ROW_OPEN;
                phase_d = PH_ROW;
                row_d   = addr[ROW_W-1:0];
                seen_d  = 1'b0;
                page_d  = 1'b0;
            end
        end else if (ras_rise) begin
            if (phase_q == PH_ROW && !seen_q) begin
                kind_d  = KIND_RAS_ONLY;
                pulse_d = 1'b1;
                rrow_d  = row_q;
            end
            phase_d = PH_IDLE;
        end else if (!ras_n) begin
            if (cas_fall && phase_q == PH_ROW) begin
                col_d  = col_in;
                page_d = seen_q;
                seen_d = 1'b1;
                if (!we_n) begin
                    wr_en   = 1'b1;
                    wr_addr = {row_q, col_in};
                    kind_d  = KIND_EARLY_WRITE;
                    phase_d = PH_WRITE;
                    oe_d    = 1'b0;
                end else begin
                    dout_d  = rd_bit;
                    oe_d    = 1'b1;
                    kind_d  = KIND_READ;
                    phase_d = PH_READ;
                end
            end else if (we_fall && !cas_n && phase_q == PH_READ) begin
                wr_en   = 1'b1;
                kind_d  = KIND_RMW;
                phase_d = PH_RMW;
            end else if (cas_rise &&
                         (phase_q inside {PH_READ, PH_WRITE, PH_RMW})) begin
                phase_d = PH_ROW;
            end
        end
    end

    // Register the decoder state and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            kind_q  <= KIND_IDLE;
            row_q   <= '0;
            col_q   <= '0;
            seen_q  <= 1'b0;
            dout_q  <= 1'b0;
            oe_q    <= 1'b0;
            page_q  <= 1'b0;
            pulse_q <= 1'b0;
            rrow_q  <= '0;
        end else begin
            phase_q <= phase_d;
            kind_q  <= kind_d;
            row_q   <= row_d;
            col_q   <= col_d;
            seen_q  <= seen_d;
            dout_q  <= dout_d;
            oe_q    <= oe_d;
            page_q  <= page_d;
            pulse_q <= pulse_d;
            rrow_q  <= rrow_d;
        end
    end

    assign dout          = dout_q;
    assign dout_oe       = oe_q;
    assign cycle_kind    = kind_q;
    assign page_access   = page_q;
    assign refresh_pulse = pulse_q;
    assign refresh_row   = rrow_q;

endmodule

// File: rtl/dram_cycle_model_chk.sv
// Edge-order checker for dram_cycle_model, attached by bind.
// Does: relates strobe inputs to the classified outputs over time.
// Assumes: same sampling clock and reset as the model.
module dram_cycle_model_chk
    import dram_cyc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       ras_n,
    input logic       cas_n,
    input logic       we_n,
    input logic       dout,
    input logic       dout_oe,
    input logic [2:0] cycle_kind,
    input logic       refresh_pulse
);

    // R1: row strobe fall with column strobe high opens a row
    a_r1_row_open: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && cas_n) |=> (cycle_kind == KIND_ROW_OPEN));

    // R2: a row-only refresh never drives data
    a_r2_ras_only_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_pulse && cycle_kind == KIND_RAS_ONLY) |-> !dout_oe);

    // R3: early write keeps the output off
    a_r3_early_write_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_kind == KIND_EARLY_WRITE) |-> !dout_oe);

    // R4: drive only follows a column fall with write enable high
    a_r4_drive_from_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe) |-> ($past(!ras_n && !cas_n && we_n)
                            && cycle_kind == KIND_READ));

    // R5: read-modify-write keeps the read data on the pin
    a_r5_rmw_holds_data: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cycle_kind) == KIND_READ && cycle_kind == KIND_RMW)
        |-> (dout_oe && $stable(dout)));

    // R6: column strobe rise turns the output off
    a_r6_oe_off_on_cas_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n) |=> !dout_oe);

    // R8: refresh marker lasts one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_pulse |=> !refresh_pulse);

    // R10: hidden refresh keeps the earlier read data driven
    a_r10_hidden_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_kind == KIND_HIDDEN && $past(cycle_kind) != KIND_HIDDEN)
        |-> (dout_oe && $stable(dout)));

endmodule

bind dram_cycle_model dram_cycle_model_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ras_n         (ras_n),
    .cas_n         (cas_n),
    .we_n          (we_n),
    .dout          (dout),
    .dout_oe       (dout_oe),
    .cycle_kind    (cycle_kind),
    .refresh_pulse (refresh_pulse)
);

// File: tb/dram_cycle_model_tb.sv
// Sweep bench for dram_cycle_model on a 16x16 configuration.
module dram_cycle_model_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int RW    = 4;
    localparam int CW    = 4;
    localparam int NROW  = 1 << RW;
    localparam int NCOL  = 1 << CW;

    localparam int K_IDLE = 0, K_ROW = 1, K_READ = 2, K_EW = 3, K_RMW = 4,
                   K_RONLY = 5, K_CBR = 6, K_HID = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, din = 1'b0;
    logic [RW-1:0] addr = '0;
    logic          dout, dout_oe, page_access, refresh_pulse;
    logic [2:0]    cycle_kind;
    logic [RW-1:0] refresh_row;

    int  n_checks = 0;
    int  n_err    = 0;
    bit  done     = 1'b0;
    int  exp_cnt  = 0;
    bit  exp_mem [NROW*NCOL];

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_cycle_model #(.ROW_W(RW), .COL_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
        .cycle_kind(cycle_kind), .page_access(page_access),
        .refresh_pulse(refresh_pulse), .refresh_row(refresh_row)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic bit pat(input int r, input int c);
        return bit'((r + c * c + (r >> 2)) & 1);
    endfunction

    // Read one cell in its own row cycle
    task automatic read_cell(input int r, input int c, input string req);
        addr = RW'(r); ras_n = 1'b0; step();
        addr = RW'(c); cas_n = 1'b0; step();
        chk({req, " kind"}, cycle_kind, K_READ);
        chk({req, " oe"}, dout_oe, 1);
        chk({req, " data"}, dout, exp_mem[r*NCOL+c]);
        chk("R7 first access", page_access, 0);
        cas_n = 1'b1; step();
        chk("R6 oe off", dout_oe, 0);
        ras_n = 1'b1; step();
    endtask

    initial begin
        repeat (3) step();
        chk("R11 oe", dout_oe, 0);
        chk("R11 kind", cycle_kind, K_IDLE);
        chk("R11 pulse", refresh_pulse, 0);
        rst_n = 1'b1; step();
        chk("R11 kind after", cycle_kind, K_IDLE);

        // R1 R3 R7: page-mode early writes over every cell
        for (int r = 0; r < NROW; r++) begin
            addr = RW'(r); ras_n = 1'b0; step();
            chk("R1 row open", cycle_kind, K_ROW);
            for (int c = 0; c < NCOL; c++) begin
                addr = RW'(c); din = pat(r, c); we_n = 1'b0; cas_n = 1'b0;
                step();
                exp_mem[r*NCOL+c] = pat(r, c);
                chk("R3 kind", cycle_kind, K_EW);
                chk("R3 oe", dout_oe, 0);
                chk("R7 page", page_access, (c != 0) ? 1 : 0);
                step();
                chk("R3 oe held", dout_oe, 0);
                cas_n = 1'b1; we_n = 1'b1; step();
                chk("R6 oe off", dout_oe, 0);
            end
            ras_n = 1'b1; step();
        end

        // R4: read every cell
        for (int r = 0; r < NROW; r++)
            for (int c = 0; c < NCOL; c++)
                read_cell(r, c, "R4 read");

        // R5: read-modify-write over row 3
        for (int c = 0; c < NCOL; c++) begin
            automatic bit old = exp_mem[3*NCOL+c];
            addr = RW'(3); ras_n = 1'b0; step();
            addr = RW'(c); cas_n = 1'b0; step();
            chk("R5 read first", dout, old);
            din = ~old; we_n = 1'b0; step();
            exp_mem[3*NCOL+c] = ~old;
            chk("R5 kind", cycle_kind, K_RMW);
            chk("R5 dout kept", dout, old);
            chk("R5 oe kept", dout_oe, 1);
            cas_n = 1'b1; we_n = 1'b1; step();
            chk("R6 oe off", dout_oe, 0);
            ras_n = 1'b1; step();
        end

        // R7: page-mode reads of row 3 confirm the RMW data
        addr = RW'(3); ras_n = 1'b0; step();
        for (int c = 0; c < NCOL; c++) begin
            addr = RW'(c); cas_n = 1'b0; step();
            chk("R7 page data", dout, exp_mem[3*NCOL+c]);
            chk("R7 page flag", page_access, (c != 0) ? 1 : 0);
            cas_n = 1'b1; step();
        end
        ras_n = 1'b1; step();

        // R2: row-only refresh
        for (int k = 0; k < 3; k++) begin
            automatic int r = (k == 0) ? 0 : ((k == 1) ? 9 : NROW - 1);
            addr = RW'(r); ras_n = 1'b0; step(); step();
            ras_n = 1'b1; step();
            chk("R2 kind", cycle_kind, K_RONLY);
            chk("R2 pulse", refresh_pulse, 1);
            chk("R2 row", refresh_row, r);
            chk("R2 oe", dout_oe, 0);
            step();
            chk("R2 pulse one cycle", refresh_pulse, 0);
        end

        // R8 R9: column-before-row refresh, wrapping the counter
        for (int k = 0; k < NROW + 4; k++) begin
            cas_n = 1'b0; step();
            addr = RW'(k); we_n = 1'b0; din = 1'b1; ras_n = 1'b0; step();
            chk("R8 kind", cycle_kind, K_CBR);
            chk("R8 pulse", refresh_pulse, 1);
            chk("R9 counter row", refresh_row, exp_cnt);
            exp_cnt = (exp_cnt + 1) % NROW;
            step();
            chk("R8 pulse one cycle", refresh_pulse, 0);
            ras_n = 1'b1; step();
            cas_n = 1'b1; we_n = 1'b1; step();
            chk("R8 oe", dout_oe, 0);
        end
        // R8: no cell was touched by the refreshes
        for (int r = 0; r < NROW; r++)
            for (int c = 0; c < NCOL; c++)
                read_cell(r, c, "R8 array unchanged");

        // R10: hidden refresh after a read
        for (int r = 1; r < 6; r++) begin
            automatic int c = (r * 3) % NCOL;
            automatic bit v = exp_mem[r*NCOL+c];
            addr = RW'(r); ras_n = 1'b0; step();
            addr = RW'(c); cas_n = 1'b0; step();
            chk("R10 read", dout, v);
            ras_n = 1'b1; step();
            chk("R10 oe across row close", dout_oe, 1);
            ras_n = 1'b0; we_n = 1'b0; step();
            chk("R10 kind", cycle_kind, K_HID);
            chk("R10 oe", dout_oe, 1);
            chk("R10 data", dout, v);
            chk("R10 pulse", refresh_pulse, 1);
            chk("R10 counter row", refresh_row, exp_cnt);
            exp_cnt = (exp_cnt + 1) % NROW;
            ras_n = 1'b1; we_n = 1'b1; step();
            chk("R10 data held", dout, v);
            chk("R10 oe held", dout_oe, 1);
            cas_n = 1'b1; step();
            chk("R6 R10 oe off", dout_oe, 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule